// File: doc/BRIEF.md
# Peripheral Security Access Gate

This block sits between a single bus master and up to sixteen peripheral ports. It checks every access against per-port security and privilege settings, which arrive as level configuration inputs. Each upstream request carries a port index, an address, a write flag, a byte-size code, write data, a secure attribute and an unprivileged attribute. The request is accepted with a valid/ready handshake, and only one transaction may be outstanding at a time.

A permitted request goes unchanged to the selected port through a valid/ready pair on that port. The response status and read data from the port are then returned upstream unchanged. A refused request never reaches any port. The gate answers it locally, one cycle after acceptance, in one of two ways chosen by a configuration input. It either reports an error, or it reports success with zero read data and the write discarded. Every refusal sets a sticky violation flag. The interrupt output is that flag gated by an enable input. A clear input empties the flag, and while the clear input is held high the flag cannot be set again.

Two parameters fix the build. A per-port bypass mask turns off the secure-attribute test for selected ports. A per-port presence mask marks which ports have a peripheral attached.

Top module: `periph_sec_gate`

## Requirements
- R1: When a port's bypass bit is 0, an access is refused if its secure attribute equals that port's `cfg_nonsec` bit. A 1 in `cfg_nonsec` means the port accepts only non-secure accesses, and a 0 means it accepts only secure accesses.
- R2: For a port whose bit in parameter `BYPASS_MASK` is 1, the secure attribute is not checked.
- R3: An unprivileged access (`up_unpriv`=1) to a port whose `cfg_user_ok` bit is 0 is refused, whatever the bypass mask says.
- R4: A refused access never asserts any `dn_valid` bit. It is answered with `rsp_rdata`=0. `rsp_err` is 1 when `cfg_err_resp` is 1 and 0 otherwise, where `cfg_err_resp` is the value sampled at acceptance.
- R5: A refused access is answered with `rsp_valid` high for exactly the one cycle after the accepting edge.
- R6: A permitted access raises only `dn_valid[port]`. It presents `dn_addr`, `dn_write`, `dn_size` and `dn_wdata` equal to the accepted request, and holds them until `dn_ready[port]` is high at a clock edge. `up_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes; data bytes pass in place, little-endian.
- R7: After the downstream handshake, `rsp_valid`, `rsp_err` and `rsp_rdata` follow the selected port's `dn_rsp_valid`, `dn_rsp_err` and read-data slice in the same cycle.
- R8: `up_ready` is high only while no transaction is in progress. It falls after the accepting edge and rises after the response cycle.
- R9: A refused access sets a sticky violation flag, and the flag stays set until cleared. `irq` equals the flag AND `irq_en`.
- R10: When `irq_clr` is high at a clock edge, the flag is 0 after that edge. This holds even if a refused access is accepted at the same edge.
- R11: A request to a port whose `PORT_PRESENT` bit is 0, or whose index is at or above `NP`, is refused under R4, R5 and R9.
- R12: While reset is asserted and after it is released, `up_ready`=1, `dn_valid`=0, `rsp_valid`=0 and the violation flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nonsec | input | NP | Per port: 1 = non-secure only, 0 = secure only |
| cfg_user_ok | input | NP | Per port: 1 = unprivileged accesses allowed |
| cfg_err_resp | input | 1 | Refused access answer: 1 = error, 0 = zero/ignore |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the violation flag and holds it clear |
| irq | output | 1 | Violation interrupt |
| up_valid | input | 1 | Request valid |
| up_ready | output | 1 | Request accepted when high with up_valid |
| up_port | input | IDX_W | Target port index |
| up_addr | input | ADDR_W | Address |
| up_write | input | 1 | 1 = write |
| up_size | input | 2 | Byte-count code (1 << code bytes) |
| up_wdata | input | DATA_W | Write data |
| up_secure | input | 1 | Secure attribute |
| up_unpriv | input | 1 | Unprivileged attribute |
| rsp_valid | output | 1 | Response valid (one cycle) |
| rsp_err | output | 1 | Response error |
| rsp_rdata | output | DATA_W | Response read data |
| dn_valid | output | NP | Per-port request valid |
| dn_ready | input | NP | Per-port request ready |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_write | output | 1 | Forwarded write flag |
| dn_size | output | 2 | Forwarded size code |
| dn_wdata | output | DATA_W | Forwarded write data |
| dn_rsp_valid | input | NP | Per-port response valid |
| dn_rsp_err | input | NP | Per-port response error |
| dn_rsp_rdata | input | NP*DATA_W | Per-port read data, port i in bits i*DATA_W upward |

## Verification
The assertions assume that a port raises `dn_rsp_valid` only after its request handshake, for one cycle, and only on the port that was selected. Under that assumption, a response cycle with no port response can only be a local answer, and its data must be zero. The bench responder follows this pattern, with ready delays of zero to three cycles taken from address bits. Configuration and enable inputs change only between transactions. The one exception is `irq_clr`, which is deliberately held across a refused access.

// File: rtl/psg_pkg.sv
package psg_pkg;

  // Transaction sequencer states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FWD   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_LOCAL = 2'd3
  } psg_state_e;

  localparam int SIZE_W = 2;

endpackage

// File: rtl/psg_check.sv
module psg_check #(
  parameter int             NP           = 16,
  parameter int             IDX_W        = 4,
  parameter logic [NP-1:0]  BYPASS_MASK  = '0,
  parameter logic [NP-1:0]  PORT_PRESENT = '1
) (
  input  logic [IDX_W-1:0] port_idx,
  input  logic             secure,
  input  logic             unpriv,
  input  logic [NP-1:0]    cfg_nonsec,
  input  logic [NP-1:0]    cfg_user_ok,
  output logic             allow
);

  logic [NP-1:0] port_ok;

  for (genvar g = 0; g < NP; g++) begin : g_port
    logic sec_pass;
    logic priv_pass;
    if (BYPASS_MASK[g]) begin : g_byp
      assign sec_pass = 1'b1;
    end else begin : g_chk
      assign sec_pass = (secure != cfg_nonsec[g]);
    end
    assign priv_pass = ~unpriv | cfg_user_ok[g];
    if (PORT_PRESENT[g]) begin : g_here
      assign port_ok[g] = sec_pass & priv_pass;
    end else begin : g_absent
      assign port_ok[g] = 1'b0;
    end
  end

  always_comb begin
    allow = 1'b0;
    for (int i = 0; i < NP; i++) begin
      if (port_idx == IDX_W'(i)) allow = port_ok[i];
    end
  end

endmodule

// File: rtl/psg_irq.sv
module psg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic viol_evt,
  input  logic irq_clr,
  input  logic irq_en,
  output logic irq
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (irq_clr)       flag_d = 1'b0;
    else if (viol_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq = flag_q & irq_en;

endmodule

// File: rtl/psg_ctrl.sv
module psg_ctrl
  import psg_pkg::*;
#(
  parameter int NP     = 16,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 up_valid,
  output logic                 up_ready,
  input  logic [IDX_W-1:0]     up_port,
  input  logic [ADDR_W-1:0]    up_addr,
  input  logic                 up_write,
  input  logic [SIZE_W-1:0]    up_size,
  input  logic [DATA_W-1:0]    up_wdata,
  input  logic                 allow,
  input  logic                 cfg_err_resp,
  output logic                 viol_evt,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NP-1:0]        dn_valid,
  input  logic [NP-1:0]        dn_ready,
  output logic [ADDR_W-1:0]    dn_addr,
  output logic                 dn_write,
  output logic [SIZE_W-1:0]    dn_size,
  output logic [DATA_W-1:0]    dn_wdata,
  input  logic [NP-1:0]        dn_rsp_valid,
  input  logic [NP-1:0]        dn_rsp_err,
  input  logic [NP*DATA_W-1:0] dn_rsp_rdata
);

  psg_state_e state_q, state_d;
  logic              cap_en;
  logic [IDX_W-1:0]  port_q;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [SIZE_W-1:0] size_q;
  logic [DATA_W-1:0] wdata_q;
  logic              err_q;

  logic              sel_ready;
  logic              sel_rsp_valid;
  logic              sel_rsp_err;
  logic [DATA_W-1:0] sel_rdata;

  // Mux of the selected port's handshake and response
  always_comb begin
    sel_ready     = 1'b0;
    sel_rsp_valid = 1'b0;
    sel_rsp_err   = 1'b0;
    sel_rdata     = '0;
    for (int i = 0; i < NP; i++) begin
      if (port_q == IDX_W'(i)) begin
        sel_ready     = dn_ready[i];
        sel_rsp_valid = dn_rsp_valid[i];
        sel_rsp_err   = dn_rsp_err[i];
        sel_rdata     = dn_rsp_rdata[i*DATA_W +: DATA_W];
      end
    end
  end

  // Next state
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (up_valid) begin
          cap_en  = 1'b1;
          state_d = allow ? ST_FWD : ST_LOCAL;
        end
      end
      ST_FWD:   if (sel_ready)     state_d = ST_WAIT;
      ST_WAIT:  if (sel_rsp_valid) state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Request capture, enabled on acceptance only
  always_ff @(posedge clk) begin
    if (cap_en) begin
      port_q  <= up_port;
      addr_q  <= up_addr;
      write_q <= up_write;
      size_q  <= up_size;
      wdata_q <= up_wdata;
      err_q   <= cfg_err_resp;
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_dnv
    assign dn_valid[g] = (state_q == ST_FWD) && (port_q == IDX_W'(g));
  end

  assign up_ready  = (state_q == ST_IDLE);
  assign viol_evt  = cap_en & ~allow;
  assign dn_addr   = addr_q;
  assign dn_write  = write_q;
  assign dn_size   = size_q;
  assign dn_wdata  = wdata_q;
  assign rsp_valid = (state_q == ST_LOCAL) | ((state_q == ST_WAIT) & sel_rsp_valid);
  assign rsp_err   = (state_q == ST_LOCAL) ? err_q : sel_rsp_err;
  assign rsp_rdata = (state_q == ST_LOCAL) ? '0 : sel_rdata;

endmodule

// File: rtl/periph_sec_gate.sv
module periph_sec_gate
  import psg_pkg::*;
#(
  parameter int            NP           = 16,
  parameter int            ADDR_W       = 32,
  parameter int            DATA_W       = 64,
  parameter logic [NP-1:0] BYPASS_MASK  = '0,
  parameter logic [NP-1:0] PORT_PRESENT = '1,
  localparam int           IDX_W        = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NP-1:0]        cfg_nonsec,
  input  logic [NP-1:0]        cfg_user_ok,
  input  logic                 cfg_err_resp,
  input  logic                 irq_en,
  input  logic                 irq_clr,
  output logic                 irq,
  input  logic                 up_valid,
  output logic                 up_ready,
  input  logic [IDX_W-1:0]     up_port,
  input  logic [ADDR_W-1:0]    up_addr,
  input  logic                 up_write,
  input  logic [1:0]           up_size,
  input  logic [DATA_W-1:0]    up_wdata,
  input  logic                 up_secure,
  input  logic                 up_unpriv,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NP-1:0]        dn_valid,
  input  logic [NP-1:0]        dn_ready,
  output logic [ADDR_W-1:0]    dn_addr,
  output logic                 dn_write,
  output logic [1:0]           dn_size,
  output logic [DATA_W-1:0]    dn_wdata,
  input  logic [NP-1:0]        dn_rsp_valid,
  input  logic [NP-1:0]        dn_rsp_err,
  input  logic [NP*DATA_W-1:0] dn_rsp_rdata
);

  logic allow;
  logic viol_evt;

  psg_check #(
    .NP(NP), .IDX_W(IDX_W), .BYPASS_MASK(BYPASS_MASK), .PORT_PRESENT(PORT_PRESENT)
  ) check_i (
    .port_idx   (up_port),
    .secure     (up_secure),
    .unpriv     (up_unpriv),
    .cfg_nonsec (cfg_nonsec),
    .cfg_user_ok(cfg_user_ok),
    .allow      (allow)
  );

  psg_ctrl #(
    .NP(NP), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_valid    (up_valid),
    .up_ready    (up_ready),
    .up_port     (up_port),
    .up_addr     (up_addr),
    .up_write    (up_write),
    .up_size     (up_size),
    .up_wdata    (up_wdata),
    .allow       (allow),
    .cfg_err_resp(cfg_err_resp),
    .viol_evt    (viol_evt),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .dn_valid    (dn_valid),
    .dn_ready    (dn_ready),
    .dn_addr     (dn_addr),
    .dn_write    (dn_write),
    .dn_size     (dn_size),
    .dn_wdata    (dn_wdata),
    .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_err  (dn_rsp_err),
    .dn_rsp_rdata(dn_rsp_rdata)
  );

  psg_irq irq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .viol_evt(viol_evt),
    .irq_clr (irq_clr),
    .irq_en  (irq_en),
    .irq     (irq)
  );

endmodule

// File: rtl/psg_chk.sv
module psg_chk #(
  parameter int NP     = 16,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [NP-1:0]     dn_valid,
  input logic [NP-1:0]     dn_ready,
  input logic [NP-1:0]     dn_rsp_valid,
  input logic              irq,
  input logic              irq_en,
  input logic              irq_clr
);

  // R6
  dn_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_valid));

  // R6
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dn_valid) && !(|(dn_valid & dn_ready))) |=> (dn_valid == $past(dn_valid)));

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> !up_ready);

  // R4
  local_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !(|dn_rsp_valid)) |-> (rsp_rdata == '0));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  // R10
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq);

endmodule

bind periph_sec_gate psg_chk #(.NP(NP), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .up_valid    (up_valid),
  .up_ready    (up_ready),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .dn_valid    (dn_valid),
  .dn_ready    (dn_ready),
  .dn_rsp_valid(dn_rsp_valid),
  .irq         (irq),
  .irq_en      (irq_en),
  .irq_clr     (irq_clr)
);

// File: tb/periph_sec_gate_tb_top.sv
`timescale 1ns/1ps
module periph_sec_gate_tb_top;

  localparam int            NP   = 16;
  localparam int            AW   = 32;
  localparam int            DW   = 64;
  localparam int            IW   = 4;
  localparam logic [NP-1:0] BYP  = 16'h00F0;
  localparam logic [NP-1:0] PRES = 16'h7FFF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic [NP-1:0]  cfg_nonsec, cfg_user_ok;
  logic           cfg_err_resp, irq_en, irq_clr, irq;
  logic           up_valid, up_ready, up_write, up_secure, up_unpriv;
  logic [IW-1:0]  up_port;
  logic [AW-1:0]  up_addr;
  logic [1:0]     up_size;
  logic [DW-1:0]  up_wdata;
  logic           rsp_valid, rsp_err;
  logic [DW-1:0]  rsp_rdata;
  logic [NP-1:0]  dn_valid, dn_ready, dn_rsp_valid, dn_rsp_err;
  logic [AW-1:0]  dn_addr;
  logic           dn_write;
  logic [1:0]     dn_size;
  logic [DW-1:0]  dn_wdata;
  logic [NP*DW-1:0] dn_rsp_rdata;

  periph_sec_gate #(
    .NP(NP), .ADDR_W(AW), .DATA_W(DW), .BYPASS_MASK(BYP), .PORT_PRESENT(PRES)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_nonsec(cfg_nonsec), .cfg_user_ok(cfg_user_ok),
    .cfg_err_resp(cfg_err_resp), .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq),
    .up_valid(up_valid), .up_ready(up_ready), .up_port(up_port), .up_addr(up_addr),
    .up_write(up_write), .up_size(up_size), .up_wdata(up_wdata),
    .up_secure(up_secure), .up_unpriv(up_unpriv),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_write(dn_write),
    .dn_size(dn_size), .dn_wdata(dn_wdata), .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_err(dn_rsp_err), .dn_rsp_rdata(dn_rsp_rdata)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string cur   = "R12";
  bit    done  = 0;

  // ---------------- reference model (0 idle, 1 fwd, 2 wait, 3 local)
  int            m_state;
  int            m_port;
  logic [AW-1:0] m_addr;
  logic          m_write;
  logic [1:0]    m_size;
  logic [DW-1:0] m_wdata;
  logic          m_err;
  logic          m_flag;

  function automatic bit refused(int p, bit sec, bit unp);
    return !PRES[p] || (!BYP[p] && (sec == cfg_nonsec[p])) || (unp && !cfg_user_ok[p]);
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    bit acc, blk;
    if (!rst_n) begin
      m_state = 0;
      m_flag  = 0;
    end else begin
      acc = (m_state == 0) && up_valid;
      blk = acc && refused(int'(up_port), up_secure, up_unpriv);
      if (irq_clr)  m_flag = 0;
      else if (blk) m_flag = 1;
      case (m_state)
        0: if (acc) begin
             m_port = int'(up_port); m_addr = up_addr; m_write = up_write;
             m_size = up_size; m_wdata = up_wdata; m_err = cfg_err_resp;
             m_state = blk ? 3 : 1;
           end
        1: if (dn_ready[m_port]) m_state = 2;
        2: if (dn_rsp_valid[m_port]) m_state = 0;
        default: m_state = 0;
      endcase
    end
  end

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/%s %s: actual %0h expected %0h at %0t", req, cur, what, act, exp, $time);
    end
  endtask

  // ---------------- compare on every clock, away from the edge
  always @(negedge clk) begin
    #1;
    if (!done) begin : cmp
      bit            exp_rv;
      logic [NP-1:0] exp_dnv;
      exp_dnv = (m_state == 1) ? (NP'(1) << m_port) : '0;
      exp_rv  = (m_state == 3) || (m_state == 2 && dn_rsp_valid[m_port]);
      chk(rst_n ? "R8" : "R12", "up_ready", DW'(up_ready), DW'(m_state == 0));
      chk(!rst_n ? "R12" : (m_state == 3 ? "R4" : "R6"), "dn_valid", DW'(dn_valid), DW'(exp_dnv));
      if (m_state == 1) begin
        chk("R6", "dn_addr",  DW'(dn_addr),  DW'(m_addr));
        chk("R6", "dn_write", DW'(dn_write), DW'(m_write));
        chk("R6", "dn_size",  DW'(dn_size),  DW'(m_size));
        chk("R6", "dn_wdata", dn_wdata, m_wdata);
      end
      chk(!rst_n ? "R12" : (m_state == 3 ? "R5" : "R7"), "rsp_valid", DW'(rsp_valid), DW'(exp_rv));
      if (exp_rv && m_state == 3) begin
        chk("R4", "rsp_err",   DW'(rsp_err), DW'(m_err));
        chk("R4", "rsp_rdata", rsp_rdata, '0);
      end else if (exp_rv) begin
        chk("R7", "rsp_err",   DW'(rsp_err), DW'(dn_rsp_err[m_port]));
        chk("R7", "rsp_rdata", rsp_rdata, dn_rsp_rdata[m_port*DW +: DW]);
      end
      chk(rst_n ? "R9" : "R12", "irq", DW'(irq), DW'(m_flag && irq_en));
    end
  end

  // ---------------- downstream responder
  bit            resp_pend = 0;
  int            resp_port = 0;
  logic          resp_e;
  logic [DW-1:0] resp_d;
  int            wait_cnt = 0;

  always @(negedge clk) begin
    dn_ready     = '0;
    dn_rsp_valid = '0;
    dn_rsp_err   = '0;
    if (resp_pend) begin
      dn_rsp_valid[resp_port] = 1'b1;
      dn_rsp_err[resp_port]   = resp_e;
      dn_rsp_rdata[resp_port*DW +: DW] = resp_d;
      resp_pend = 0;
    end else if (dn_valid != '0) begin
      if (wait_cnt < int'(dn_addr[1:0])) begin
        wait_cnt++;
      end else begin
        wait_cnt = 0;
        dn_ready = dn_valid;
        for (int i = 0; i < NP; i++) if (dn_valid[i]) resp_port = i;
        resp_e    = dn_addr[4];
        resp_d    = {dn_addr, ~dn_addr};
        resp_pend = 1;
      end
    end
  end

  // ---------------- stimulus
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(int p, logic [AW-1:0] a, bit wr, int sz, logic [DW-1:0] wd, bit sec, bit unp);
    @(negedge clk);
    while (!up_ready) @(negedge clk);
    up_valid = 1'b1; up_port = IW'(p); up_addr = a; up_write = wr;
    up_size = 2'(sz); up_wdata = wd; up_secure = sec; up_unpriv = unp;
    @(negedge clk);
    up_valid = 1'b0; up_addr = ~a; up_wdata = ~wd; up_port = ~IW'(p);
    while (!up_ready) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; up_valid = 1'b0; up_port = '0; up_addr = '0; up_write = 1'b0;
    up_size = '0; up_wdata = '0; up_secure = 1'b0; up_unpriv = 1'b0;
    cfg_nonsec = '0; cfg_user_ok = '0; cfg_err_resp = 1'b0; irq_en = 1'b0; irq_clr = 1'b0;
    dn_ready = '0; dn_rsp_valid = '0; dn_rsp_err = '0;
    dn_rsp_rdata = {NP{64'hA5A5_0F0F_5A5A_F0F0}};
    idle(3);
    rst_n = 1'b1;
    idle(2);

    cfg_nonsec = 16'h0F0F; cfg_user_ok = 16'hFF00; irq_en = 1'b1;
    cur = "R6";
    req(0, 32'h1000_0020, 0, 2, '0, 0, 0);
    req(1, 32'h2000_0013, 1, 3, 64'h1122_3344_5566_7788, 0, 0);
    cur = "R7";
    for (int sz = 0; sz < 4; sz++)
      req(2, 32'h3000_0040 + sz, sz[0], sz, 64'h0102_0304_0506_0708 << sz, 0, 0);

    cur = "R1";
    req(0,  32'h1000_0000, 0, 2, '0, 1, 0);
    req(12, 32'h1200_0000, 1, 1, 64'hFF, 0, 0);
    req(8,  32'h0800_0011, 0, 3, '0, 0, 0);
    req(12, 32'h1200_0002, 0, 0, '0, 1, 0);

    cur = "R4";
    cfg_err_resp = 1'b1;
    req(0, 32'h1000_0004, 1, 2, 64'hDEAD, 1, 0);
    cfg_err_resp = 1'b0;
    req(1, 32'h1000_0008, 0, 2, '0, 1, 0);

    cur = "R2";
    req(4, 32'h0400_0001, 0, 2, '0, 0, 0);
    req(5, 32'h0500_0010, 0, 2, '0, 1, 0);
    req(6, 32'h0600_0003, 1, 1, 64'h55AA, 0, 0);

    cur = "R3";
    req(4,  32'h0400_0000, 0, 2, '0, 1, 1);
    req(9,  32'h0900_0001, 0, 2, '0, 0, 1);
    req(10, 32'h0A00_0000, 0, 2, '0, 1, 1);

    cur = "R11";
    req(15, 32'h0F00_0000, 0, 2, '0, 1, 0);
    cfg_err_resp = 1'b1;
    req(15, 32'h0F00_0004, 1, 2, 64'h77, 1, 0);
    cfg_err_resp = 1'b0;

    cur = "R9";
    irq_en = 1'b0; idle(3); irq_en = 1'b1; idle(2);

    cur = "R10";
    @(negedge clk); irq_clr = 1'b1;
    idle(2);
    req(0, 32'h1000_0000, 0, 2, '0, 1, 0);
    idle(1); irq_clr = 1'b0; idle(3);
    req(0, 32'h1000_0000, 0, 2, '0, 1, 0);
    idle(2); irq_clr = 1'b1; idle(1); irq_clr = 1'b0; idle(2);

    cur = "R8";
    @(negedge clk);
    up_valid = 1'b1; up_port = 4'd1; up_addr = 32'h0100_0002; up_write = 1'b0;
    up_size = 2'd2; up_secure = 1'b0; up_unpriv = 1'b0;
    idle(12);
    up_secure = 1'b1;
    idle(6);
    up_valid = 1'b0;
    idle(8);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule